// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two wires of an I2C bus and never drives them. It samples SCL and SDA with a fast system clock. Each line passes through a synchroniser and a majority-vote glitch filter. A four-state sequencer then watches the filtered levels: idle, address collection, acknowledge wait and data. It reports bus conditions and bytes as single-cycle events. Each event carries a 4-bit type code and an 8-bit value.

A START moves the monitor into address collection. The first byte after any START carries the direction in bit 0, and that bit decides whether the following data bytes are reported as reads or writes. A START that arrives while a transfer is still open is reported as a repeated START. When a STOP is reported, two counters are presented next to it: the number of clock samples in the transfer and the number of times the filtered line pair changed.

Top module: `i2c_bus_monitor`

## Requirements
- R1: Every decoded event appears as a single-cycle high on `evt_valid_o` together with `evt_type_o` and `evt_data_o`. The type codes are 0 START, 1 repeated START, 2 STOP, 3 ACK, 4 NACK, 6 address-read, 7 address-write, 8 data-read and 9 data-write. No other code is ever emitted.
- R2: In idle, SDA falling while SCL is high is reported as type 0 with data 0, and the monitor moves to address collection.
- R3: One bit is taken on each SCL rising edge, equal to the SDA level at that edge. Bits are shifted in MSB first, and the eighth bit completes a byte event.
- R4: A START recognised in the data state, with no STOP since the previous START, is reported as type 1. A STOP clears this condition, so the next START after a STOP is type 0.
- R5: With `addr_raw_i`=0, an address event carries `{1'b0, byte[7:1]}` (so 0xA2 is given as 0x51). With `addr_raw_i`=1 it carries the full byte.
- R6: In the first byte after a START, bit 0 = 1 gives type 6 and bit 0 = 0 gives type 7. The following data bytes are type 8 after a read address and type 9 after a write address, until the next START or STOP.
- R7: The SCL rising edge after a byte is the acknowledge bit. SDA=0 gives type 3 and SDA=1 gives type 4, both with data 0. In either case the monitor then goes to the data state.
- R8: In the data state, SDA rising while SCL is high is reported as type 2, and the monitor returns to idle with the direction cleared.
- R9: During address collection and while waiting for the acknowledge, START and STOP patterns are ignored and only SCL rising edges act.
- R10: With the STOP event, `xfer_samples_o` shows the clock samples from the START cycle through the STOP cycle inclusive. `xfer_edges_o` shows the changes of the filtered {SCL,SDA} pair after the START cycle, up to and including the STOP cycle. Both counters restart at every START, saturate, and hold between STOP events.
- R11: A level pulse of one system clock on either line is filtered out and causes no event.
- R12: While reset is asserted, `evt_valid_o`, `evt_type_o`, `evt_data_o` and both counters are 0, and the monitor is idle with both lines taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_raw_i | input | 1 | 1: address event shows the raw byte; 0: the 7-bit address |
| evt_valid_o | output | 1 | Single-cycle event strobe |
| evt_type_o | output | 4 | Event type code |
| evt_data_o | output | 8 | Byte value of the event (0 for conditions and acknowledges) |
| xfer_samples_o | output | CNT_W | Clock samples of the last transfer, START to STOP |
| xfer_edges_o | output | CNT_W | Line-pair changes of the last transfer |

## Verification
The bench injects START and STOP shapes in the middle of address collection. A design that does not gate its condition detection by state would report an early STOP or an extra START at that point, and the address byte would then be wrong. Repeated STARTs are followed by fresh STARTs to catch a repeated-START flag that does not clear on STOP, or a direction that carries over into the next transfer. Transfer counters are compared against cycle counts taken at stimulus time, which exposes off-by-one errors in the inclusive sample count and in whether the START change itself is counted. Single-cycle line pulses check that the vote filter rejects glitches instead of reporting a START.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd6,
    EV_ADDR_WR = 4'd7,
    EV_DATA_RD = 4'd8,
    EV_DATA_WR = 4'd9
  } evt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA
  } mon_st_e;
endpackage

// File: rtl/i2cmon_line_filter.sv
module i2cmon_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o
);
  localparam int VOTE_MIN = VOTE_TAPS / 2 + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   win_q;
  logic                   maj;

  always_comb maj = ($countones(win_q) >= VOTE_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      lvl_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      lvl_o  <= maj;
    end
  end
endmodule

// File: rtl/i2cmon_decoder.sv
module i2cmon_decoder
  import i2cmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_raw_i,
  output logic              evt_valid_o,
  output logic [3:0]        evt_type_o,
  output logic [BYTE_W-1:0] evt_data_o,
  output logic              acc_start_o,
  output logic              acc_stop_o,
  output logic              pair_chg_o
);
  localparam int CNT_BW = $clog2(BYTE_W);
  localparam logic [CNT_BW-1:0] LAST_BIT = CNT_BW'(BYTE_W - 1);

  mon_st_e           st_q;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_BW-1:0] bit_q;
  logic              rd_q, rep_q;

  logic              rise, start_c, stop_c;
  logic [BYTE_W-1:0] nxt_byte;

  always_comb begin
    rise        = ~scl_q & scl_i;
    start_c     = scl_i & sda_q & ~sda_i;
    stop_c      = scl_i & ~sda_q & sda_i;
    nxt_byte    = {sh_q[BYTE_W-2:0], sda_i};
    pair_chg_o  = (scl_q != scl_i) || (sda_q != sda_i);
    acc_start_o = ((st_q == ST_IDLE) && start_c) ||
                  ((st_q == ST_DATA) && !rise && start_c);
    acc_stop_o  = (st_q == ST_DATA) && !rise && !start_c && stop_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      sh_q        <= '0;
      bit_q       <= '0;
      rd_q        <= 1'b0;
      rep_q       <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_type_o  <= '0;
      evt_data_o  <= '0;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      evt_valid_o <= 1'b0;
      if (acc_start_o) begin
        evt_valid_o <= 1'b1;
        evt_type_o  <= rep_q ? EV_RSTART : EV_START;
        evt_data_o  <= '0;
        st_q        <= ST_ADDR;
        bit_q       <= '0;
        rd_q        <= 1'b0;
        rep_q       <= 1'b1;
      end else if (acc_stop_o) begin
        evt_valid_o <= 1'b1;
        evt_type_o  <= EV_STOP;
        evt_data_o  <= '0;
        st_q        <= ST_IDLE;
        rd_q        <= 1'b0;
        rep_q       <= 1'b0;
      end else if (rise) begin
        unique case (st_q)
          ST_ADDR, ST_DATA: begin
            sh_q <= nxt_byte;
            if (bit_q == LAST_BIT) begin
              bit_q       <= '0;
              evt_valid_o <= 1'b1;
              st_q        <= ST_ACK;
              if (st_q == ST_ADDR) begin
                rd_q       <= sda_i;
                evt_type_o <= sda_i ? EV_ADDR_RD : EV_ADDR_WR;
                evt_data_o <= addr_raw_i ? nxt_byte : {1'b0, nxt_byte[BYTE_W-1:1]};
              end else begin
                evt_type_o <= rd_q ? EV_DATA_RD : EV_DATA_WR;
                evt_data_o <= nxt_byte;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_ACK: begin
            evt_valid_o <= 1'b1;
            evt_type_o  <= sda_i ? EV_NACK : EV_ACK;
            evt_data_o  <= '0;
            st_q        <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cmon_xfer_stats.sv
module i2cmon_xfer_stats #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             chg_i,
  output logic [CNT_W-1:0] samples_o,
  output logic [CNT_W-1:0] edges_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             act_q;
  logic [CNT_W-1:0] smp_q, edg_q, smp_nxt, edg_nxt;

  always_comb begin
    smp_nxt = (smp_q == CNT_MAX) ? smp_q : smp_q + 1'b1;
    edg_nxt = (chg_i && edg_q != CNT_MAX) ? edg_q + 1'b1 : edg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      smp_q     <= '0;
      edg_q     <= '0;
      samples_o <= '0;
      edges_o   <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      smp_q <= CNT_W'(1);
      edg_q <= '0;
    end else if (act_q) begin
      smp_q <= smp_nxt;
      edg_q <= edg_nxt;
      if (stop_i) begin
        act_q     <= 1'b0;
        samples_o <= smp_nxt;
        edges_o   <= edg_nxt;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_raw_i,
  output logic              evt_valid_o,
  output logic [3:0]        evt_type_o,
  output logic [BYTE_W-1:0] evt_data_o,
  output logic [CNT_W-1:0]  xfer_samples_o,
  output logic [CNT_W-1:0]  xfer_edges_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_w, filt_w;
  logic               acc_start, acc_stop, pair_chg;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cmon_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_w[g]),
      .lvl_o (filt_w[g])
    );
  end

  i2cmon_decoder u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (filt_w[1]),
    .sda_i      (filt_w[0]),
    .addr_raw_i (addr_raw_i),
    .evt_valid_o(evt_valid_o),
    .evt_type_o (evt_type_o),
    .evt_data_o (evt_data_o),
    .acc_start_o(acc_start),
    .acc_stop_o (acc_stop),
    .pair_chg_o (pair_chg)
  );

  i2cmon_xfer_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (acc_start),
    .stop_i   (acc_stop),
    .chg_i    (pair_chg),
    .samples_o(xfer_samples_o),
    .edges_o  (xfer_edges_o)
  );
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_raw_i,
  input logic             evt_valid_o,
  input logic [3:0]       evt_type_o,
  input logic [7:0]       evt_data_o,
  input logic [CNT_W-1:0] xfer_samples_o,
  input logic [CNT_W-1:0] xfer_edges_o,
  input logic             acc_start,
  input logic             acc_stop
);
  a_r1_legal_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (evt_type_o != 4'd5 && evt_type_o <= 4'd9));

  a_r2_start_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_start |=> (evt_valid_o && (evt_type_o == 4'd0 || evt_type_o == 4'd1)));

  a_r8_stop_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stop |=> (evt_valid_o && evt_type_o == 4'd2));

  a_r7_ack_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && (evt_type_o == 4'd3 || evt_type_o == 4'd4)) |-> evt_data_o == 8'd0);

  a_r5_shifted_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && (evt_type_o == 4'd6 || evt_type_o == 4'd7) && !$past(addr_raw_i))
      |-> !evt_data_o[7]);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_stop |=> ($stable(xfer_samples_o) && $stable(xfer_edges_o)));

  a_r10_edges_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_edges_o <= xfer_samples_o);
endmodule

bind i2c_bus_monitor i2cmon_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_raw_i    (addr_raw_i),
  .evt_valid_o   (evt_valid_o),
  .evt_type_o    (evt_type_o),
  .evt_data_o    (evt_data_o),
  .xfer_samples_o(xfer_samples_o),
  .xfer_edges_o  (xfer_edges_o),
  .acc_start     (acc_start),
  .acc_stop      (acc_stop)
);

// File: tb/i2c_bus_monitor_tb.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb;
  localparam int CNT_W = 24;
  localparam int HOLD  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1, raw_r = 1'b0;
  logic             evt_valid_o;
  logic [3:0]       evt_type_o;
  logic [7:0]       evt_data_o;
  logic [CNT_W-1:0] xfer_samples_o, xfer_edges_o;

  always #2.5 clk = ~clk;

  i2c_bus_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_r), .sda_i(sda_r), .addr_raw_i(raw_r),
    .evt_valid_o(evt_valid_o), .evt_type_o(evt_type_o), .evt_data_o(evt_data_o),
    .xfer_samples_o(xfer_samples_o), .xfer_edges_o(xfer_edges_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0, drv_cyc = 0, start_cyc = 0, stop_cyc = 0, edge_cnt = 0, edge_stop = 0;
  int ev_n = 0, exp_n = 0;
  logic [3:0] ev_t[64], exp_t[64];
  logic [7:0] ev_d[64], exp_d[64];
  logic prev_valid = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid_o && prev_valid) chk(1'b0, "R1 strobe longer than one cycle", 1, 0);
      if (evt_valid_o && ev_n < 64) begin
        ev_t[ev_n] = evt_type_o;
        ev_d[ev_n] = evt_data_o;
        ev_n++;
      end
    end
    prev_valid = evt_valid_o;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic string req_of(input logic [3:0] t);
    case (t)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2: return "R8";
      4'd3, 4'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic set_l(input logic s, input logic d);
    if (s != scl_r || d != sda_r) edge_cnt++;
    scl_r = s;
    sda_r = d;
    drv_cyc = cyc;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] t, input logic [7:0] d);
    exp_t[exp_n] = t;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic send_bit(input logic b);
    set_l(1'b0, b); set_l(1'b1, b); set_l(1'b0, b);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic do_start(input bit rep);
    if (rep) begin
      set_l(1'b0, 1'b1); set_l(1'b1, 1'b1);
    end
    set_l(1'b1, 1'b0);
    start_cyc = drv_cyc;
    edge_cnt = 0;
    set_l(1'b0, 1'b0);
    push(rep ? 4'd1 : 4'd0, 8'd0);
  endtask

  task automatic do_stop();
    set_l(1'b0, 1'b0); set_l(1'b1, 1'b0); set_l(1'b1, 1'b1);
    stop_cyc = drv_cyc;
    edge_stop = edge_cnt;
    push(4'd2, 8'd0);
  endtask

  task automatic addr_phase(input logic [7:0] b, input logic ack);
    send_byte(b);
    push(b[0] ? 4'd6 : 4'd7, raw_r ? b : {1'b0, b[7:1]});
    send_bit(ack);
    push(ack ? 4'd4 : 4'd3, 8'd0);
  endtask

  task automatic data_phase(input logic [7:0] b, input logic rd, input logic ack);
    send_byte(b);
    push(rd ? 4'd8 : 4'd9, b);
    send_bit(ack);
    push(ack ? 4'd4 : 4'd3, 8'd0);
  endtask

  task automatic compare_txn(input string tag);
    repeat (12) @(negedge clk);
    chk(ev_n == exp_n, {tag, " R1 event count"}, ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      chk(ev_t[i] == exp_t[i], {tag, " ", req_of(exp_t[i]), " type"}, ev_t[i], exp_t[i]);
      chk(ev_d[i] == exp_d[i], {tag, (exp_t[i] inside {4'd6, 4'd7}) ? " R5" : " R3", " data"},
          ev_d[i], exp_d[i]);
    end
    chk(xfer_samples_o == CNT_W'(stop_cyc - start_cyc + 1), {tag, " R10 samples"},
        int'(xfer_samples_o), stop_cyc - start_cyc + 1);
    chk(xfer_edges_o == CNT_W'(edge_stop), {tag, " R10 edges"}, int'(xfer_edges_o), edge_stop);
    ev_n = 0;
    exp_n = 0;
  endtask

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(evt_valid_o == 1'b0, "R12 valid in reset", evt_valid_o, 0);
    chk(evt_type_o == 4'd0 && evt_data_o == 8'd0, "R12 event fields in reset",
        {evt_type_o, evt_data_o}, 0);
    chk(xfer_samples_o == '0 && xfer_edges_o == '0, "R12 counters in reset",
        int'(xfer_samples_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R11 glitch on SDA while SCL high in idle
    sda_r = 1'b0; @(negedge clk); sda_r = 1'b1;
    repeat (20) @(negedge clk);
    chk(ev_n == 0, "R11 sda glitch ignored", ev_n, 0);
    scl_r = 1'b0; @(negedge clk); scl_r = 1'b1;
    repeat (20) @(negedge clk);
    chk(ev_n == 0, "R11 scl glitch ignored", ev_n, 0);
    ev_n = 0;

    // Directed write, shifted address 0xA2 -> 0x51
    raw_r = 1'b0;
    do_start(1'b0);
    addr_phase(8'hA2, 1'b0);
    data_phase(8'h3C, 1'b0, 1'b0);
    do_stop();
    compare_txn("dir_wr");

    // Directed read, raw address, NACK then more data (R7 stays in data state)
    raw_r = 1'b1;
    do_start(1'b0);
    addr_phase(8'hA3, 1'b0);
    data_phase(8'h5A, 1'b1, 1'b1);
    data_phase(8'hFF, 1'b1, 1'b1);
    do_stop();
    compare_txn("dir_rd_raw");

    // R9 start and stop shapes during address collection are ignored; byte 0xA4
    raw_r = 1'b0;
    do_start(1'b0);
    set_l(1'b0, 1'b1); set_l(1'b1, 1'b1); set_l(1'b1, 1'b0); set_l(1'b0, 1'b0);
    set_l(1'b0, 1'b0); set_l(1'b1, 1'b0); set_l(1'b1, 1'b1); set_l(1'b0, 1'b1);
    for (int i = 5; i >= 0; i--) send_bit(a_bits(i));
    push(4'd7, 8'h52);
    send_bit(1'b0);
    push(4'd3, 8'd0);
    do_stop();
    compare_txn("R9_gating");

    // Repeated START then fresh START (R4, R6)
    raw_r = 1'b0;
    do_start(1'b0);
    addr_phase(8'h20, 1'b0);
    data_phase(8'h11, 1'b0, 1'b0);
    do_start(1'b1);
    addr_phase(8'h21, 1'b0);
    data_phase(8'h99, 1'b1, 1'b1);
    do_stop();
    compare_txn("R4_rep");

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      int segs;
      raw_r = 1'($urandom % 2);
      segs = 1 + int'($urandom % 2);
      for (int s = 0; s < segs; s++) begin
        int nb;
        logic rd;
        rd = 1'($urandom % 2);
        a = {7'($urandom), rd};
        do_start(s != 0);
        addr_phase(a, 1'($urandom % 4 == 0));
        nb = 1 + int'($urandom % 3);
        for (int k = 0; k < nb; k++) begin
          d = 8'($urandom);
          data_phase(d, rd, 1'($urandom % 3 == 0));
        end
      end
      do_stop();
      compare_txn("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // remaining bits [5:0] of 0xA4
  function automatic logic a_bits(input int i);
    logic [7:0] v;
    v = 8'hA4;
    return v[i];
  endfunction
endmodule